// File: doc/BRIEF.md
# Split Program Counter with Ripple Incrementer

This block holds a program address as two byte registers, low and high, joined by a combinational incrementer that has no storage of its own. In each machine cycle, and separately for each byte, the byte either takes back its own incremented value or loads a new value from the internal address bus for that byte. With increment off, the value it takes back is unchanged. The incremented value is also the value the block drives. The low byte can drive the data bus or the low address bus, and the high byte can drive the data bus or the high address bus.

Control strobes are captured at a clock edge and act during the following cycle. Load choices are applied at the end of that cycle, while drive enables and the carry-in apply throughout it. A sequencer outside the block raises an increment request. The block drops that request when a predecode input reports that the next instruction is a single byte. The carry from the low byte into the high byte comes from an all-ones detect on the low byte. The low nibble has its own all-ones detect that acts as a half-carry inside the low byte. Both detects are brought out so that control logic can see an early carry.

Top module: `pc_split`

## Requirements
- R1: While reset is held, and at release, the count is 0x0000, all three output enables are 0, the bus outputs are 0 and both detect outputs are 0.
- R2: A load strobe for a byte, captured at edge N, makes that byte take the value on its address bus input (low from `adl_i`, high from `adh_i`) at edge N+1. Each byte loads independently of the other.
- R3: With the increment request captured and no load, the 16-bit count advances by one at the next edge. The low byte carries into the high byte only when the low byte is 0xFF.
- R4: When `one_byte_i` is 1 in the cycle the increment request is captured, no increment happens and the count stays the same.
- R5: With increment off and no load, each byte recirculates, so the count does not change.
- R6: A drive strobe places the incremented byte value (count plus the carry-in of that cycle) on its target bus and raises that bus's enable. Low goes to `db_o` or `adl_o`, high goes to `db_o` or `adh_o`. A bus that no strobe drives outputs 0.
- R7: Drive strobes take effect in the cycle after the edge that captures them, never in the cycle they are applied.
- R8: When both bytes drive the data bus, the low byte's value appears on `db_o`.
- R9: `lo_ff_o` is 1 exactly when the low byte is 0xFF. `lo_nib_f_o` is 1 exactly when the low byte's bits 3:0 are 0xF. The half-carry turns 0x0F into 0x10 on an increment.
- R10: An increment from 0xFFFF gives 0x0000.
- R11: The per-byte choice is independent. A byte that loads ignores the increment, while the other byte still recirculates with its own carry-in (low 0xFF with increment still carries into a high byte that is not loading).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Cycle clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| inc_req_i | input | 1 | Increment request |
| one_byte_i | input | 1 | Next instruction is one byte; suppresses increment |
| ld_lo_i | input | 1 | Low byte loads from low address bus |
| ld_hi_i | input | 1 | High byte loads from high address bus |
| drv_lo_db_i | input | 1 | Low incremented value onto data bus |
| drv_lo_adl_i | input | 1 | Low incremented value onto low address bus |
| drv_hi_db_i | input | 1 | High incremented value onto data bus |
| drv_hi_adh_i | input | 1 | High incremented value onto high address bus |
| adl_i | input | BYTE_W | Low address bus value for loading |
| adh_i | input | BYTE_W | High address bus value for loading |
| db_o | output | BYTE_W | Data bus drive value |
| db_oe_o | output | 1 | Data bus driven |
| adl_o | output | BYTE_W | Low address bus drive value |
| adl_oe_o | output | 1 | Low address bus driven |
| adh_o | output | BYTE_W | High address bus drive value |
| adh_oe_o | output | 1 | High address bus driven |
| lo_ff_o | output | 1 | Low byte all ones |
| lo_nib_f_o | output | 1 | Low nibble all ones |

## Verification
The bench builds the block with its default parameters, BYTE_W of 8 and NIB_W of 4. With these values every carry boundary can be reached in a single load: the nibble half-carry at 0x0F, the byte carry at 0xFF and the full wrap at 0xFFFF. Directed scenarios load such corner values, then increment, suppress or hold them. They read each result back through the drive strobes, and a read with increment off shows the stored count.

// File: rtl/pc_split_pkg.sv
package pc_split_pkg;
  typedef struct packed {
    logic ld_lo;
    logic ld_hi;
    logic cin;
    logic lo_db;
    logic lo_adl;
    logic hi_db;
    logic hi_adh;
  } pc_ctrl_t;
endpackage

// File: rtl/pc_split_ctrl.sv
module pc_split_ctrl
  import pc_split_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     inc_req_i,
  input  logic     one_byte_i,
  input  logic     ld_lo_i,
  input  logic     ld_hi_i,
  input  logic     drv_lo_db_i,
  input  logic     drv_lo_adl_i,
  input  logic     drv_hi_db_i,
  input  logic     drv_hi_adh_i,
  output pc_ctrl_t ctrl_o
);
  pc_ctrl_t ctrl_d;

  always_comb begin
    ctrl_d.ld_lo  = ld_lo_i;
    ctrl_d.ld_hi  = ld_hi_i;
    ctrl_d.cin    = inc_req_i & ~one_byte_i;
    ctrl_d.lo_db  = drv_lo_db_i;
    ctrl_d.lo_adl = drv_lo_adl_i;
    ctrl_d.hi_db  = drv_hi_db_i;
    ctrl_d.hi_adh = drv_hi_adh_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ctrl_o <= '0;
    else         ctrl_o <= ctrl_d;
  end

  a_r4_one_byte_blocks: assert property (@(posedge clk_i) disable iff (!rst_ni)
    one_byte_i |=> !ctrl_o.cin);

  a_r7_drive_latency: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(drv_lo_db_i || drv_lo_adl_i || drv_hi_db_i || drv_hi_adh_i)
      |=> !(ctrl_o.lo_db || ctrl_o.lo_adl || ctrl_o.hi_db || ctrl_o.hi_adh));
endmodule

// File: rtl/pc_split_inc.sv
module pc_split_inc #(
  parameter int W   = 8,
  parameter int NIB = 4
) (
  input  logic [W-1:0] val_i,
  input  logic         cin_i,
  output logic [W-1:0] nxt_o,
  output logic         all_ones_o,
  output logic         nib_ones_o
);
  assign all_ones_o = &val_i;
  assign nib_ones_o = &val_i[NIB-1:0];

  generate
    if (NIB < W) begin : g_split
      // upper part carries on the nibble detect, not on a ripple
      assign nxt_o[NIB-1:0] = val_i[NIB-1:0] + NIB'(cin_i);
      assign nxt_o[W-1:NIB] = val_i[W-1:NIB] + (W-NIB)'(cin_i & nib_ones_o);
    end else begin : g_flat
      assign nxt_o = val_i + W'(cin_i);
    end
  endgenerate
endmodule

// File: rtl/pc_split_breg.sv
module pc_split_breg #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         ld_i,
  input  logic [W-1:0] bus_i,
  input  logic [W-1:0] inc_i,
  output logic [W-1:0] q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   q_o <= '0;
    else if (ld_i) q_o <= bus_i;
    else           q_o <= inc_i;
  end

  a_r2_load_takes_bus: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ld_i |=> (q_o == $past(bus_i)));
endmodule

// File: rtl/pc_split_drv.sv
module pc_split_drv #(
  parameter int W = 8
) (
  input  logic         lo_db_i,
  input  logic         lo_adl_i,
  input  logic         hi_db_i,
  input  logic         hi_adh_i,
  input  logic [W-1:0] lo_i,
  input  logic [W-1:0] hi_i,
  output logic [W-1:0] db_o,
  output logic         db_oe_o,
  output logic [W-1:0] adl_o,
  output logic         adl_oe_o,
  output logic [W-1:0] adh_o,
  output logic         adh_oe_o
);
  always_comb begin
    if (lo_db_i)      db_o = lo_i;
    else if (hi_db_i) db_o = hi_i;
    else              db_o = '0;
    db_oe_o  = lo_db_i | hi_db_i;
    adl_o    = lo_adl_i ? lo_i : '0;
    adl_oe_o = lo_adl_i;
    adh_o    = hi_adh_i ? hi_i : '0;
    adh_oe_o = hi_adh_i;
  end
endmodule

// File: rtl/pc_split.sv
module pc_split
  import pc_split_pkg::*;
#(
  parameter int BYTE_W = 8,
  parameter int NIB_W  = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              inc_req_i,
  input  logic              one_byte_i,
  input  logic              ld_lo_i,
  input  logic              ld_hi_i,
  input  logic              drv_lo_db_i,
  input  logic              drv_lo_adl_i,
  input  logic              drv_hi_db_i,
  input  logic              drv_hi_adh_i,
  input  logic [BYTE_W-1:0] adl_i,
  input  logic [BYTE_W-1:0] adh_i,
  output logic [BYTE_W-1:0] db_o,
  output logic              db_oe_o,
  output logic [BYTE_W-1:0] adl_o,
  output logic              adl_oe_o,
  output logic [BYTE_W-1:0] adh_o,
  output logic              adh_oe_o,
  output logic              lo_ff_o,
  output logic              lo_nib_f_o
);
  localparam int PC_W = 2 * BYTE_W;

  pc_ctrl_t          ctrl;
  logic [BYTE_W-1:0] lo_q, hi_q, lo_nxt, hi_nxt;
  logic              lo_all, lo_nib, hi_all_unused, hi_nib_unused;
  logic              hi_cin;
  logic [PC_W-1:0]   pc_q;

  pc_split_ctrl u_ctrl (
    .clk_i, .rst_ni, .inc_req_i, .one_byte_i, .ld_lo_i, .ld_hi_i,
    .drv_lo_db_i, .drv_lo_adl_i, .drv_hi_db_i, .drv_hi_adh_i,
    .ctrl_o(ctrl)
  );

  pc_split_inc #(.W(BYTE_W), .NIB(NIB_W)) u_inc_lo (
    .val_i(lo_q), .cin_i(ctrl.cin), .nxt_o(lo_nxt),
    .all_ones_o(lo_all), .nib_ones_o(lo_nib)
  );

  assign hi_cin = ctrl.cin & lo_all;

  pc_split_inc #(.W(BYTE_W), .NIB(NIB_W)) u_inc_hi (
    .val_i(hi_q), .cin_i(hi_cin), .nxt_o(hi_nxt),
    .all_ones_o(hi_all_unused), .nib_ones_o(hi_nib_unused)
  );

  pc_split_breg #(.W(BYTE_W)) u_reg_lo (
    .clk_i, .rst_ni, .ld_i(ctrl.ld_lo), .bus_i(adl_i), .inc_i(lo_nxt), .q_o(lo_q)
  );

  pc_split_breg #(.W(BYTE_W)) u_reg_hi (
    .clk_i, .rst_ni, .ld_i(ctrl.ld_hi), .bus_i(adh_i), .inc_i(hi_nxt), .q_o(hi_q)
  );

  pc_split_drv #(.W(BYTE_W)) u_drv (
    .lo_db_i(ctrl.lo_db), .lo_adl_i(ctrl.lo_adl),
    .hi_db_i(ctrl.hi_db), .hi_adh_i(ctrl.hi_adh),
    .lo_i(lo_nxt), .hi_i(hi_nxt),
    .db_o, .db_oe_o, .adl_o, .adl_oe_o, .adh_o, .adh_oe_o
  );

  assign lo_ff_o    = lo_all;
  assign lo_nib_f_o = lo_nib;
  assign pc_q       = {hi_q, lo_q};

  a_r5_hold_when_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ctrl.ld_lo && !ctrl.ld_hi && !ctrl.cin) |=> $stable(pc_q));

  a_r3_step_by_one: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ctrl.ld_lo && !ctrl.ld_hi && ctrl.cin)
      |=> (pc_q == PC_W'($past(pc_q) + 1)));

  a_r10_wrap_to_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ctrl.ld_lo && !ctrl.ld_hi && ctrl.cin && (&pc_q)) |=> (pc_q == '0));

  a_r11_hi_carry_on_lo_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl.ld_lo && !ctrl.ld_hi && ctrl.cin && lo_ff_o)
      |=> (hi_q == BYTE_W'($past(hi_q) + 1)));
endmodule

// File: tb/pc_split_test.sv
module pc_split_test;
  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic       rst_ni = 1'b0;
  logic       inc_req = 0, one_byte = 0, ld_lo = 0, ld_hi = 0;
  logic       d_lo_db = 0, d_lo_adl = 0, d_hi_db = 0, d_hi_adh = 0;
  logic [7:0] adl_in = 0, adh_in = 0;
  logic [7:0] db_o, adl_o, adh_o;
  logic       db_oe, adl_oe, adh_oe, lo_ff, lo_nib;

  pc_split uut (
    .clk_i(clk), .rst_ni, .inc_req_i(inc_req), .one_byte_i(one_byte),
    .ld_lo_i(ld_lo), .ld_hi_i(ld_hi),
    .drv_lo_db_i(d_lo_db), .drv_lo_adl_i(d_lo_adl),
    .drv_hi_db_i(d_hi_db), .drv_hi_adh_i(d_hi_adh),
    .adl_i(adl_in), .adh_i(adh_in),
    .db_o, .db_oe_o(db_oe), .adl_o, .adl_oe_o(adl_oe), .adh_o, .adh_oe_o(adh_oe),
    .lo_ff_o(lo_ff), .lo_nib_f_o(lo_nib)
  );

  int n_chk = 0, n_bad = 0;
  logic [7:0] c_db, c_adl, c_adh;
  logic       c_dboe, c_adloe, c_adhoe;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // one operation: strobes captured at the first edge, act in the next cycle
  task automatic step(input logic inc, ob, ll, lh, dld, dla, dhd, dhh,
                      input logic [7:0] al, ah);
    inc_req = inc; one_byte = ob; ld_lo = ll; ld_hi = lh;
    d_lo_db = dld; d_lo_adl = dla; d_hi_db = dhd; d_hi_adh = dhh;
    adl_in = al; adh_in = ah;
    @(posedge clk); @(negedge clk);
    c_db = db_o; c_adl = adl_o; c_adh = adh_o;
    c_dboe = db_oe; c_adloe = adl_oe; c_adhoe = adh_oe;
    {inc_req, one_byte, ld_lo, ld_hi, d_lo_db, d_lo_adl, d_hi_db, d_hi_adh} = '0;
    @(posedge clk); @(negedge clk);
  endtask

  task automatic read_pc(output logic [15:0] v);
    step(0, 0, 0, 0, 0, 1, 0, 1, 8'h00, 8'h00);
    v = {c_adh, c_adl};
  endtask

  task automatic load(input logic [15:0] v);
    step(0, 0, 1, 1, 0, 0, 0, 0, v[7:0], v[15:8]);
  endtask

  task automatic t_reset();
    logic [15:0] v;
    chk("R1 db_oe", db_oe, 0); chk("R1 adl_oe", adl_oe, 0); chk("R1 adh_oe", adh_oe, 0);
    chk("R1 buses", {db_o, adl_o, adh_o}, 0);
    chk("R1 detects", {lo_ff, lo_nib}, 0);
    rst_ni = 1'b1;
    @(negedge clk);
    read_pc(v); chk("R1 count", v, 16'h0000);
  endtask

  task automatic t_load();
    logic [15:0] v;
    load(16'h3412); read_pc(v); chk("R2 both bytes", v, 16'h3412);
    step(0, 0, 1, 0, 0, 0, 0, 0, 8'hAB, 8'h77); read_pc(v); chk("R2 low only", v, 16'h34AB);
    step(0, 0, 0, 1, 0, 0, 0, 0, 8'h55, 8'h9C); read_pc(v); chk("R2 high only", v, 16'h9CAB);
  endtask

  task automatic t_inc_drive();
    logic [15:0] v;
    load(16'h34AB);
    step(1, 0, 0, 0, 0, 1, 0, 1, 8'h00, 8'h00);
    chk("R6 adl inc value", c_adl, 8'hAC); chk("R6 adh value", c_adh, 8'h34);
    chk("R6 oe", {c_adloe, c_adhoe, c_dboe}, 3'b110);
    read_pc(v); chk("R3 plus one", v, 16'h34AC);
    step(0, 0, 0, 0, 0, 0, 1, 0, 8'h00, 8'h00);
    chk("R6 high on db", c_db, 8'h34); chk("R6 db oe", c_dboe, 1);
    chk("R6 undriven zero", {c_adl, c_adh, c_adloe, c_adhoe}, 0);
    step(1, 0, 0, 0, 1, 0, 1, 0, 8'h00, 8'h00);
    chk("R8 low wins db", c_db, 8'hAD);
  endtask

  task automatic t_carry();
    logic [15:0] v;
    load(16'h12FF);
    chk("R9 ff detect", lo_ff, 1); chk("R9 nib detect", lo_nib, 1);
    step(1, 0, 0, 0, 0, 1, 0, 1, 8'h00, 8'h00);
    chk("R3 carry lo", c_adl, 8'h00); chk("R3 carry hi", c_adh, 8'h13);
    read_pc(v); chk("R3 after carry", v, 16'h1300);
    load(16'h120F);
    chk("R9 nib only", {lo_ff, lo_nib}, 2'b01);
    step(1, 0, 0, 0, 0, 0, 0, 0, 8'h00, 8'h00);
    read_pc(v); chk("R9 half carry", v, 16'h1210);
    chk("R9 detects clear", {lo_ff, lo_nib}, 2'b00);
  endtask

  task automatic t_suppress_hold();
    logic [15:0] v;
    load(16'h40FF);
    step(1, 1, 0, 0, 0, 1, 0, 1, 8'h00, 8'h00);
    chk("R4 drive unchanged", {c_adh, c_adl}, 16'h40FF);
    read_pc(v); chk("R4 no increment", v, 16'h40FF);
    for (int i = 0; i < 3; i++) step(0, 0, 0, 0, 0, 0, 0, 0, 8'h11, 8'h22);
    read_pc(v); chk("R5 hold", v, 16'h40FF);
  endtask

  task automatic t_latency();
    d_lo_adl = 1'b1;
    #5 chk("R7 not same cycle", adl_oe, 0);
    @(posedge clk); @(negedge clk);
    chk("R7 next cycle", adl_oe, 1);
    d_lo_adl = 1'b0;
    @(posedge clk); @(negedge clk);
    chk("R7 released", adl_oe, 0);
  endtask

  task automatic t_wrap_mixed();
    logic [15:0] v;
    load(16'hFFFF);
    step(1, 0, 0, 0, 0, 1, 0, 1, 8'h00, 8'h00);
    chk("R10 drive wrap", {c_adh, c_adl}, 16'h0000);
    read_pc(v); chk("R10 wrap", v, 16'h0000);
    load(16'h12FF);
    step(1, 0, 1, 0, 0, 0, 0, 0, 8'h34, 8'h00);
    read_pc(v); chk("R11 lo load hi carry", v, 16'h1334);
    step(1, 0, 0, 1, 0, 0, 0, 0, 8'h00, 8'h56);
    read_pc(v); chk("R11 hi load lo inc", v, 16'h5635);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #25;
    t_reset();
    t_load();
    t_inc_drive();
    t_carry();
    t_suppress_hold();
    t_latency();
    t_wrap_mixed();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule